// File: doc/BRIEF.md
# Receive Completion Ring Poster

This block hands finished receive buffers back to host software. When a receive channel closes a buffer or a packet, the channel logic passes the channel control word together with the record contents: the last cell header, the error indicator, the start-of-packet pointer and the trailer. The block then writes a five-word completion record into one of two completion rings in host memory. A select bit in the channel control word picks the ring. On one ring every post raises an interrupt. On the other ring posts are silent.

Before it writes, the block reads the ownership word of the target slot. If the host has not yet returned that slot, the block does not overwrite it. It sets a sticky freeze status bit and reports the request as frozen. On a successful post, the block returns the control word with the channel's active flag cleared. It then advances the position of that ring, wrapping to zero after the ring's end slot. A post to the interrupting ring also pulses the interrupt and sets a sticky receive-complete status bit. The block takes a new request only while idle.

Top module: `cmpl_ring_poster`

## Requirements
- R1: Control word bit 30 chooses the ring. 1 selects the interrupting ring, based at `ring_base_irq`. 0 selects the silent ring, based at `ring_base_quiet`. Each ring keeps its own position.
- R2: The slot address is the base of the selected ring plus the ring's position times 20 bytes. The first memory access of every post is a read of the slot's word 4 at slot+16. The read data is taken on the cycle after `mem_re`.
- R3: The read word is converted from network order to host order. If its bit 31 (owner flag) is 0, the block makes no write and leaves the ring position unchanged. It sets the sticky `stat_freeze` bit and reports `done` with `done_frozen`=1.
- R4: The record words are as follows. Word 0 is the cell header. Word 1 is the 16-bit error indicator, with bit 31 set when control bits [1:0] equal 2'b01 (AAL5 channel). Word 2 is 0 unless the start-of-packet pointer is valid; when it is valid, word 2 is the 31-bit pointer with bit 31 set. Word 3 is the trailer.
- R5: Word 4 is the low 16 bits of the channel free-buffer word. Bit 30 is set when the error indicator is nonzero. Bit 31 is left clear, which hands the slot to the host.
- R6: The five words are written on five consecutive cycles to slot+0, +4, +8, +12 and +16. Each word is in network byte order: host byte [7:0] goes to wdata[31:24], and so on. The block never reads and writes in the same cycle.
- R7: On success, `done_ctrl` equals the request control word with bit 31 (active) cleared. On a freeze, `done_ctrl` is the control word unchanged.
- R8: After a successful post, the ring position becomes 0 if it equalled the ring's end; otherwise it increments by one. The end of the interrupting ring is `ring_size[15:0]`. The end of the silent ring is `ring_size[31:16]`.
- R9: A successful post to the interrupting ring pulses `irq` for one cycle together with `done`, and sets the sticky `stat_rx_done` bit. The silent ring and frozen posts never raise `irq`.
- R10: `req_ready` is high only in the idle state. Each accepted request gives exactly one `done`. This comes 7 cycles after the read cycle on success, or 2 cycles after it on a freeze.
- R11: After reset the block is idle and ready, both ring positions are 0, both status bits are 0, and there is no memory access, `done` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Post request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_ctrl | input | 32 | Channel control word (bit 31 active, bit 30 ring select, [1:0] channel type) |
| req_fbr | input | 32 | Channel free-buffer word, pointer in low 16 bits |
| req_hdr | input | 32 | Header of the last cell |
| req_err | input | 16 | Error indicator |
| req_sop | input | 31 | Start-of-packet pointer |
| req_sop_ok | input | 1 | Start-of-packet pointer valid |
| req_trailer | input | 32 | Packet trailer |
| ring_base_irq | input | 32 | Byte base of the interrupting ring |
| ring_base_quiet | input | 32 | Byte base of the silent ring |
| ring_size | input | 32 | Ring end slots: [15:0] interrupting, [31:16] silent |
| mem_re | output | 1 | Host memory read strobe |
| mem_we | output | 1 | Host memory write strobe |
| mem_addr | output | 32 | Host memory byte address |
| mem_wdata | output | 32 | Host memory write data |
| mem_rdata | input | 32 | Host memory read data, one cycle after `mem_re` |
| done | output | 1 | Request finished |
| done_frozen | output | 1 | Finished request was abandoned on a held slot |
| done_ctrl | output | 32 | Updated channel control word |
| irq | output | 1 | Interrupt pulse |
| stat_rx_done | output | 1 | Sticky receive-complete status |
| stat_freeze | output | 1 | Sticky receive-freeze status |

## Verification
Ring wrap-around and the ownership check can meet on the same post. The slot that a ring returns to after wrapping is still held by the host if software has not re-armed it. The bench provokes this by running each ring past its end without re-arming slot 0. It then expects a freeze with no write, no interrupt and an unchanged position. After re-arming the slot, the bench expects the next post to land at slot 0. Every memory access is compared on its own cycle with a queue of accesses that the bench model predicts.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
    localparam int WORD_W      = 32;
    localparam int REC_WORDS   = 5;
    localparam int REC_BYTES   = REC_WORDS * 4;
    localparam int WIDX_W      = 3;
    localparam int ERR_W       = 16;
    localparam int SOP_W       = 31;
    localparam int FBR_PTR_W   = 16;
    localparam int OWN_WORD    = REC_WORDS - 1;

    localparam int CTRL_ACT_BIT = 31;
    localparam int CTRL_SEL_BIT = 30;
    localparam logic [1:0] KIND_AAL5 = 2'b01;

    localparam int OWN_BIT      = 31;
    localparam int W1_AAL5_BIT  = 31;
    localparam int W2_VALID_BIT = 31;
    localparam int W4_ERR_BIT   = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WRITE,
        ST_POST,
        ST_FREEZE
    } poster_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] fbr;
        logic [WORD_W-1:0] hdr;
        logic [ERR_W-1:0]  err;
        logic [SOP_W-1:0]  sop;
        logic              sop_ok;
        logic [WORD_W-1:0] trailer;
    } post_req_t;

    typedef struct packed {
        poster_st_e        st;
        post_req_t         req;
        logic [WIDX_W-1:0] widx;
        logic              stat_done;
        logic              stat_frz;
    } poster_regs_t;

    function automatic logic [WORD_W-1:0] net_order(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/cmpl_ring_pos.sv
module cmpl_ring_pos #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [POS_W-1:0] end_pos,
    output logic [POS_W-1:0] pos
);
    logic [POS_W-1:0] pos_d, pos_q;

    // compare against the end before stepping, wrap to zero on a match
    always_comb begin
        pos_d = pos_q;
        if (adv) begin
            if (pos_q == end_pos) pos_d = '0;
            else                  pos_d = pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/cmpl_slot_addr.sv
module cmpl_slot_addr
    import cmpl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] slot
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(REC_BYTES);

    assign slot = base + ADDR_W'(pos) * STRIDE;
endmodule

// File: rtl/cmpl_rec_fmt.sv
module cmpl_rec_fmt
    import cmpl_pkg::*;
(
    input  post_req_t                          req,
    output logic [REC_WORDS-1:0][WORD_W-1:0]   words
);
    logic unused_bits;
    assign unused_bits = ^{req.fbr[WORD_W-1:FBR_PTR_W], req.ctrl[WORD_W-1:2], req.sop_ok};

    always_comb begin
        words[0] = req.hdr;

        words[1] = WORD_W'(req.err);
        if (req.ctrl[1:0] == KIND_AAL5) words[1][W1_AAL5_BIT] = 1'b1;

        words[2] = '0;
        if (req.sop_ok) begin
            words[2] = WORD_W'(req.sop);
            words[2][W2_VALID_BIT] = 1'b1;
        end

        words[3] = req.trailer;

        // owner bit left clear: the slot goes back to the host
        words[4] = WORD_W'(req.fbr[FBR_PTR_W-1:0]);
        if (|req.err) words[4][W4_ERR_BIT] = 1'b1;
    end
endmodule

// File: rtl/cmpl_ring_poster.sv
module cmpl_ring_poster
    import cmpl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [WORD_W-1:0]   req_ctrl,
    input  logic [WORD_W-1:0]   req_fbr,
    input  logic [WORD_W-1:0]   req_hdr,
    input  logic [ERR_W-1:0]    req_err,
    input  logic [SOP_W-1:0]    req_sop,
    input  logic                req_sop_ok,
    input  logic [WORD_W-1:0]   req_trailer,
    input  logic [ADDR_W-1:0]   ring_base_irq,
    input  logic [ADDR_W-1:0]   ring_base_quiet,
    input  logic [2*POS_W-1:0]  ring_size,
    output logic                mem_re,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                done,
    output logic                done_frozen,
    output logic [WORD_W-1:0]   done_ctrl,
    output logic                irq,
    output logic                stat_rx_done,
    output logic                stat_freeze
);
    localparam int NUM_RINGS = 2;
    localparam int RING_IRQ  = 1;
    localparam int RING_QT   = 0;
    localparam logic [ADDR_W-1:0] OWN_OFS = ADDR_W'(OWN_WORD * 4);

    poster_regs_t r_d, r_q;

    logic [NUM_RINGS-1:0][ADDR_W-1:0] ring_base;
    logic [NUM_RINGS-1:0][POS_W-1:0]  ring_end;
    logic [NUM_RINGS-1:0][POS_W-1:0]  ring_pos;
    logic [NUM_RINGS-1:0]             ring_adv;

    logic                             sel_q;
    logic [ADDR_W-1:0]                slot_addr;
    logic [REC_WORDS-1:0][WORD_W-1:0] rec_words;
    logic [WORD_W-1:0]                word_sel;
    logic [WORD_W-1:0]                rd_host;
    logic                             unused_rd;

    assign ring_base[RING_IRQ] = ring_base_irq;
    assign ring_base[RING_QT]  = ring_base_quiet;
    assign ring_end[RING_IRQ]  = ring_size[POS_W-1:0];
    assign ring_end[RING_QT]   = ring_size[2*POS_W-1:POS_W];

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        cmpl_ring_pos #(.POS_W(POS_W)) u_pos (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (ring_adv[g]),
            .end_pos(ring_end[g]),
            .pos    (ring_pos[g])
        );
    end

    assign sel_q = r_q.req.ctrl[CTRL_SEL_BIT];

    cmpl_slot_addr #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_slot (
        .base(ring_base[sel_q]),
        .pos (ring_pos[sel_q]),
        .slot(slot_addr)
    );

    cmpl_rec_fmt u_fmt (
        .req  (r_q.req),
        .words(rec_words)
    );

    always_comb begin
        word_sel = '0;
        for (int k = 0; k < REC_WORDS; k++) begin
            if (r_q.widx == WIDX_W'(k)) word_sel = rec_words[k];
        end
    end

    assign rd_host   = net_order(mem_rdata);
    assign unused_rd = ^rd_host[OWN_BIT-1:0];

    always_comb begin
        r_d         = r_q;
        req_ready   = 1'b0;
        mem_re      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        done        = 1'b0;
        done_frozen = 1'b0;
        done_ctrl   = '0;
        irq         = 1'b0;
        ring_adv    = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.req.ctrl    = req_ctrl;
                    r_d.req.fbr     = req_fbr;
                    r_d.req.hdr     = req_hdr;
                    r_d.req.err     = req_err;
                    r_d.req.sop     = req_sop;
                    r_d.req.sop_ok  = req_sop_ok;
                    r_d.req.trailer = req_trailer;
                    r_d.st          = ST_READ;
                end
            end
            ST_READ: begin
                mem_re   = 1'b1;
                mem_addr = slot_addr + OWN_OFS;
                r_d.st   = ST_CHECK;
            end
            ST_CHECK: begin
                r_d.widx = '0;
                if (rd_host[OWN_BIT]) r_d.st = ST_WRITE;
                else                  r_d.st = ST_FREEZE;
            end
            ST_WRITE: begin
                mem_we    = 1'b1;
                mem_addr  = slot_addr + ADDR_W'({r_q.widx, 2'b00});
                mem_wdata = net_order(word_sel);
                if (r_q.widx == WIDX_W'(REC_WORDS - 1)) r_d.st = ST_POST;
                else                                    r_d.widx = r_q.widx + 1'b1;
            end
            ST_POST: begin
                done      = 1'b1;
                done_ctrl = r_q.req.ctrl;
                done_ctrl[CTRL_ACT_BIT] = 1'b0;
                ring_adv[sel_q] = 1'b1;
                if (sel_q) begin
                    irq           = 1'b1;
                    r_d.stat_done = 1'b1;
                end
                r_d.st = ST_IDLE;
            end
            ST_FREEZE: begin
                done         = 1'b1;
                done_frozen  = 1'b1;
                done_ctrl    = r_q.req.ctrl;
                r_d.stat_frz = 1'b1;
                r_d.st       = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat_rx_done = r_q.stat_done;
    assign stat_freeze  = r_q.stat_frz;
endmodule

// File: rtl/cmpl_ring_poster_chk.sv
module cmpl_ring_poster_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_re,
    input logic mem_we,
    input logic done,
    input logic done_frozen,
    input logic irq,
    input logic stat_rx_done,
    input logic stat_freeze
);
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R10
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !req_ready); // R10
    AST_NO_READ_WRITE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R6
    AST_IRQ_ONLY_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && !done_frozen)); // R9
    AST_IRQ_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> stat_rx_done); // R9
    AST_FREEZE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_frozen) |=> stat_freeze); // R3
    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_freeze |=> stat_freeze); // R3
endmodule

bind cmpl_ring_poster cmpl_ring_poster_chk u_chk (.*);

// File: tb/cmpl_ring_poster_bench.sv
module cmpl_ring_poster_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE_I = 32'h0000_1000;
    localparam logic [31:0] BASE_Q = 32'h0000_2000;
    localparam int END_I = 2;
    localparam int END_Q = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ctrl = '0, req_fbr = '0, req_hdr = '0, req_trailer = '0;
    logic [15:0] req_err = '0;
    logic [30:0] req_sop = '0;
    logic        req_sop_ok = 1'b0;
    logic        mem_re, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done, done_frozen, irq, stat_rx_done, stat_freeze;
    logic [31:0] done_ctrl;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpl_ring_poster u_cmpl_ring_poster (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctrl(req_ctrl), .req_fbr(req_fbr), .req_hdr(req_hdr), .req_err(req_err),
        .req_sop(req_sop), .req_sop_ok(req_sop_ok), .req_trailer(req_trailer),
        .ring_base_irq(BASE_I), .ring_base_quiet(BASE_Q),
        .ring_size({16'(END_Q), 16'(END_I)}),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .done_frozen(done_frozen), .done_ctrl(done_ctrl),
        .irq(irq), .stat_rx_done(stat_rx_done), .stat_freeze(stat_freeze)
    );

    // ---------------- host memory and reference model ----------------
    logic [31:0] bmem [logic [31:0]];
    typedef struct { bit wr; logic [31:0] addr; logic [31:0] data; } acc_t;
    acc_t expq[$];
    int   n_chk = 0, n_fail = 0;
    int   pos_i = 0, pos_q = 0;
    bit   m_stat_rx = 0, m_stat_frz = 0;
    bit   finished = 0;

    function automatic logic [31:0] swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // host hands a slot to the block: owner bit set in word 4
    task automatic arm(input logic [31:0] slot);
        bmem[slot + 16] = swap(32'h8000_0000);
    endtask

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr] = mem_wdata;
        if (mem_re) mem_rdata <= rdm(mem_addr);
    end

    // every memory access is compared with the predicted stream (R1, R2, R6)
    always @(negedge clk) begin
        if (rst_n && (mem_re || mem_we)) begin
            if (expq.size() == 0) begin
                chk(0, "R6 unexpected access", mem_addr, 32'h0);
            end else begin
                acc_t e;
                e = expq.pop_front();
                if (!e.wr) chk(mem_re && mem_addr == e.addr, "R2 owner read", mem_addr, e.addr);
                else begin
                    chk(mem_we && mem_addr == e.addr, "R6 write address", mem_addr, e.addr);
                    chk(mem_wdata == e.data, "R4/R5 record word", mem_wdata, e.data);
                end
            end
        end
    end

    task automatic post(input logic [31:0] ctrl, input logic [31:0] fbr, input logic [31:0] hdr,
                        input logic [15:0] err, input logic [30:0] sop, input bit sop_ok,
                        input logic [31:0] trl);
        bit          sel, frz;
        int          pos, cyc, endp;
        logic [31:0] slot, w4, ectrl;
        logic [31:0] w [5];
        acc_t        a;
        sel  = ctrl[30];
        pos  = sel ? pos_i : pos_q;
        endp = sel ? END_I : END_Q;
        slot = (sel ? BASE_I : BASE_Q) + 32'(pos * 20);
        w4   = swap(rdm(slot + 16));
        frz  = !w4[31];
        a.wr = 0; a.addr = slot + 16; a.data = 0; expq.push_back(a);
        if (!frz) begin
            w[0] = hdr;
            w[1] = {16'h0, err} | ((ctrl[1:0] == 2'b01) ? 32'h8000_0000 : 32'h0);
            w[2] = sop_ok ? ({1'b0, sop} | 32'h8000_0000) : 32'h0;
            w[3] = trl;
            w[4] = {16'h0, fbr[15:0]} | ((err != 0) ? 32'h4000_0000 : 32'h0);
            for (int k = 0; k < 5; k++) begin
                a.wr = 1; a.addr = slot + 32'(4 * k); a.data = swap(w[k]);
                expq.push_back(a);
            end
        end
        ectrl = frz ? ctrl : (ctrl & 32'h7FFF_FFFF);

        @(negedge clk);
        chk(req_ready, "R10 ready when idle", {31'h0, req_ready}, 32'h1);
        req_ctrl = ctrl; req_fbr = fbr; req_hdr = hdr; req_err = err;
        req_sop = sop; req_sop_ok = sop_ok; req_trailer = trl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 20) begin
            chk(!req_ready, "R10 busy", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            cyc++;
        end
        chk(cyc == (frz ? 2 : 7), "R10 done latency", 32'(cyc), frz ? 32'd2 : 32'd7);
        chk(done_frozen == frz, "R3 frozen flag", {31'h0, done_frozen}, {31'h0, frz});
        chk(done_ctrl == ectrl, "R7 control word", done_ctrl, ectrl);
        chk(irq == (sel && !frz), "R9 interrupt", {31'h0, irq}, {31'h0, sel && !frz});
        if (frz) m_stat_frz = 1;
        else begin
            if (sel) m_stat_rx = 1;
            // R8: compare with end before stepping
            if (pos == endp) pos = 0; else pos = pos + 1;
            if (sel) pos_i = pos; else pos_q = pos;
        end
        @(negedge clk);
        chk(stat_freeze == m_stat_frz, "R3 freeze status", {31'h0, stat_freeze}, {31'h0, m_stat_frz});
        chk(stat_rx_done == m_stat_rx, "R9 complete status", {31'h0, stat_rx_done}, {31'h0, m_stat_rx});
        chk(expq.size() == 0, "R6 all accesses made", 32'(expq.size()), 32'h0);
        chk(!irq && !done, "R9 single pulse", {30'h0, irq, done}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(req_ready && !mem_re && !mem_we && !done && !irq, "R11 idle outputs",
            {27'h0, req_ready, mem_re, mem_we, done, irq}, 32'h10);
        chk(!stat_rx_done && !stat_freeze, "R11 status clear", {30'h0, stat_rx_done, stat_freeze}, 32'h0);
        rst_n = 1'b1;
        for (int s = 0; s <= END_I; s++) arm(BASE_I + 32'(20 * s));
        for (int s = 0; s <= END_Q; s++) arm(BASE_Q + 32'(20 * s));

        // R1 R4 R5: interrupting ring, AAL5, clean, valid start pointer
        post(32'hC000_0001, 32'hABCD_1234, 32'h0102_0304, 16'h0, 31'h1234_5678, 1, 32'hDEAD_BEEF);
        // silent ring, other type, error, no start pointer
        post(32'h8000_0002, 32'h0000_0042, 32'h1111_2222, 16'h0005, 31'h0, 0, 32'h0);
        post(32'hC000_0000, 32'h0000_0007, 32'h3333_4444, 16'h0003, 31'h7FFF_FFFF, 1, 32'h5555_AAAA);
        post(32'h8000_0001, 32'hFFFF_FFFF, 32'h6666_7777, 16'h0000, 31'h0000_0010, 1, 32'h0000_0001);
        // R8 wrap then R3 freeze: silent slot 0 not re-armed
        post(32'h8000_0001, 32'h0000_0001, 32'h0, 16'h0, 31'h0, 0, 32'h0);
        arm(BASE_Q);
        post(32'h8000_0003, 32'h0000_0009, 32'h8888_9999, 16'hFFFF, 31'h0, 0, 32'h1);
        // interrupting ring reaches its end and wraps
        post(32'hC000_0001, 32'h0000_0100, 32'hAAAA_0000, 16'h0, 31'h2, 1, 32'h2);
        post(32'hC000_0001, 32'h0000_0200, 32'hBBBB_0000, 16'h1, 31'h3, 1, 32'h3);
        arm(BASE_I);
        post(32'hC000_0001, 32'h0000_0300, 32'hCCCC_0000, 16'h0, 31'h4, 1, 32'h4);
        post(32'h4000_0001, 32'h0000_0400, 32'hDDDD_0000, 16'h0, 31'h5, 0, 32'h5);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule